// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block sits between a UART's serial receive and transmit paths and the CPU bus. It gathers one-cycle event strobes from the receiver and transmitter (parity, framing and overrun errors, a received break, transmission finished) and two level flags (received data waiting, transmit buffer empty) into an 8-bit status register. It also reports the two active-low modem handshake inputs, clear-to-send and data-set-ready, and produces a single active-high interrupt request.

The CPU reads the status register to learn why it was interrupted. That read empties the whole register. Events that arrive while a read strobe is held are parked and applied only when the strobe drops. A parked event for a bit that was already set clears that bit instead of setting it. Interrupts come from rising edges of the error, break and transmit-finished bits, gated by a global enable, and from any change on the modem lines, gated by both the global and the modem enable.

Top module: `uart_stat_irq`

## Requirements
- R1: After reset the status register reads 0x60, with transmission-finished (bit 5) and buffer-empty (bit 6) set and all other bits clear. The interrupt edge detector starts armed, so setting the global enable without first reading status raises the interrupt at once.
- R2: A one-cycle event strobe sampled at a clock edge sets its status bit from the next cycle. The bits are parity error 0, framing error 1, overrun 2, received break 3, modem change 4, transmission finished 5, buffer empty 6 and data ready 7.
- R3: Bit 7 is set by a rising edge of the data-ready level and bit 6 by a rising edge of the buffer-empty level. Neither edge ever raises the interrupt.
- R4: Reading the status register clears the status interrupt edge detector at the first clock of the read. All status bits clear on the clock after the read strobe falls.
- R5: The status register holds its value while the read strobe is high. An event seen during the read sets its bit when the strobe falls.
- R6: An event seen during a read whose bit was already set leaves that bit clear after the read, instead of setting it.
- R7: When the global enable is high, a rising edge of bit 0, 1, 2, 3 or 5 raises the interrupt. The interrupt stays high until a status read clears the edge detector.
- R8: The modem status output carries clear-to-send at bit 0 and data-set-ready at bit 1, both as 1 when the active-low pin is low. Bits 2 and 3 read 0.
- R9: Any change on either modem input sets status bit 4 and arms the modem edge detector. That detector raises the interrupt only while both the global enable and the modem enable are high.
- R10: A modem status read strobe clears the modem edge detector and leaves the reported line levels unchanged.
- R11: The interrupt output is low whenever the global enable is low. Armed edge detectors are kept, so they take effect when the enable returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| parityErrEv | input | 1 | Parity error event strobe |
| frameErrEv | input | 1 | Framing error event strobe |
| overrunEv | input | 1 | Overrun event strobe |
| breakEv | input | 1 | Received break event strobe |
| txDoneEv | input | 1 | Transmission finished event strobe |
| dataReady | input | 1 | Receive data waiting, level |
| bufEmpty | input | 1 | Transmit buffer empty, level |
| ctsN | input | 1 | Clear-to-send modem input, active low |
| dsrN | input | 1 | Data-set-ready modem input, active low |
| intEn | input | 1 | Global interrupt enable |
| modemIntEn | input | 1 | Modem interrupt enable |
| statRead | input | 1 | Status register read strobe, high for the read |
| modemRead | input | 1 | Modem status register read strobe |
| statusReg | output | 8 | Status register contents |
| modemStat | output | 4 | Modem status register contents |
| intr | output | 1 | Interrupt request, active high |

## Verification
The bound checker watches four things on every cycle:
- the global enable gating the interrupt;
- the status register holding still during a read;
- no bit that was set before the end of a read surviving past it;
- a strobe or a modem line change outside a read landing in its bit on the next cycle.

Some behaviour only the bench scenarios can show. These are the reset value and the armed edge detector, the deferred set of an event that falls inside a read, the exclusion of the data-ready and buffer-empty edges from the interrupt, and the modem detector outliving a disabled modem enable until a modem status read.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int STAT_W = 8;
  localparam int MSR_W  = 4;
  localparam int MODEM_LINES = 2;

  localparam int BIT_PE  = 0;
  localparam int BIT_FE  = 1;
  localparam int BIT_OE  = 2;
  localparam int BIT_BRK = 3;
  localparam int BIT_MS  = 4;
  localparam int BIT_TC  = 5;
  localparam int BIT_TBE = 6;
  localparam int BIT_DR  = 7;

  // bits whose rising edge may interrupt
  localparam logic [STAT_W-1:0] EDGE_IRQ_MASK = 8'b0010_1111;
  // bits fed by level inputs, set on their rising edge
  localparam logic [STAT_W-1:0] LEVEL_MASK    = 8'b1100_0000;
  localparam logic [STAT_W-1:0] STAT_RESET    = 8'b0110_0000;

  typedef struct packed {
    logic statHold;    // status read in progress
    logic statEnd;     // status read has just ended
    logic statClrIrq;  // first cycle of a status read
    logic modemChg;    // a modem line changed this cycle
    logic modemClr;    // modem status read
  } ctlStrobe_t;
endpackage

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
  import uart_stat_pkg::*;
#(
  parameter int LINES = MODEM_LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             statRead,
  input  logic             modemRead,
  input  logic [LINES-1:0] lineN,
  output ctlStrobe_t       strobe
);
  logic             readQ;
  logic [LINES-1:0] lineQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ <= 1'b0;
      lineQ <= '1;       // lines taken as deasserted at reset
    end else begin
      readQ <= statRead;
      lineQ <= lineN;
    end
  end

  always_comb begin
    strobe.statHold   = statRead;
    strobe.statEnd    = readQ & ~statRead;
    strobe.statClrIrq = statRead & ~readQ;
    strobe.modemChg   = |(lineQ ^ lineN);
    strobe.modemClr   = modemRead;
  end
endmodule

// File: rtl/uart_stat_dp.sv
module uart_stat_dp
  import uart_stat_pkg::*;
#(
  parameter int               W         = STAT_W,
  parameter logic [W-1:0]     RESET_VAL = STAT_RESET,
  parameter logic [W-1:0]     IRQ_MASK  = EDGE_IRQ_MASK,
  parameter logic [W-1:0]     LVL_MASK  = LEVEL_MASK
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   strobe,
  input  logic [W-1:0] rawEv,
  input  logic         intEn,
  input  logic         modemIntEn,
  output logic [W-1:0] statQ,
  output logic         intr
);
  localparam logic IRQ_ARMED_AT_RESET = |(RESET_VAL & IRQ_MASK);

  logic [W-1:0] ev;
  logic [W-1:0] levelQ;
  logic [W-1:0] pendQ;
  logic [W-1:0] statNext;
  logic [W-1:0] pendNext;
  logic         statIrqQ;
  logic         modemIrqQ;

  // level inputs become rising-edge events; strobes pass straight through
  for (genvar i = 0; i < W; i++) begin : g_ev
    if (LVL_MASK[i]) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) levelQ[i] <= RESET_VAL[i];
        else       levelQ[i] <= rawEv[i];
      end
      assign ev[i] = rawEv[i] & ~levelQ[i];
    end else begin : g_pulse
      assign levelQ[i] = 1'b0;
      assign ev[i]     = rawEv[i];
    end
  end

  always_comb begin
    statNext = statQ;
    pendNext = pendQ;
    if (strobe.statHold) begin
      pendNext = pendQ | ev;
    end else if (strobe.statEnd) begin
      statNext = (pendQ | ev) & ~statQ;
      pendNext = '0;
    end else begin
      statNext = statQ | ev;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ     <= RESET_VAL;
      pendQ     <= '0;
      statIrqQ  <= IRQ_ARMED_AT_RESET;
      modemIrqQ <= 1'b0;
    end else begin
      statQ     <= statNext;
      pendQ     <= pendNext;
      statIrqQ  <= strobe.statClrIrq ? 1'b0
                 : (statIrqQ | (|(statNext & ~statQ & IRQ_MASK)));
      modemIrqQ <= strobe.modemChg | (modemIrqQ & ~strobe.modemClr);
    end
  end

  assign intr = intEn & (statIrqQ | (modemIntEn & modemIrqQ));
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              parityErrEv,
  input  logic              frameErrEv,
  input  logic              overrunEv,
  input  logic              breakEv,
  input  logic              txDoneEv,
  input  logic              dataReady,
  input  logic              bufEmpty,
  input  logic              ctsN,
  input  logic              dsrN,
  input  logic              intEn,
  input  logic              modemIntEn,
  input  logic              statRead,
  input  logic              modemRead,
  output logic [STAT_W-1:0] statusReg,
  output logic [MSR_W-1:0]  modemStat,
  output logic              intr
);
  ctlStrobe_t        strobe;
  logic [STAT_W-1:0] rawEv;
  logic [MODEM_LINES-1:0] lineN;

  assign lineN = {dsrN, ctsN};

  uart_stat_ctrl #(.LINES(MODEM_LINES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .statRead  (statRead),
    .modemRead (modemRead),
    .lineN     (lineN),
    .strobe    (strobe)
  );

  always_comb begin
    rawEv          = '0;
    rawEv[BIT_PE]  = parityErrEv;
    rawEv[BIT_FE]  = frameErrEv;
    rawEv[BIT_OE]  = overrunEv;
    rawEv[BIT_BRK] = breakEv;
    rawEv[BIT_MS]  = strobe.modemChg;
    rawEv[BIT_TC]  = txDoneEv;
    rawEv[BIT_TBE] = bufEmpty;
    rawEv[BIT_DR]  = dataReady;
  end

  uart_stat_dp #(.W(STAT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rawEv      (rawEv),
    .intEn      (intEn),
    .modemIntEn (modemIntEn),
    .statQ      (statusReg),
    .intr       (intr)
  );

  assign modemStat = {{(MSR_W-MODEM_LINES){1'b0}}, ~lineN};
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       statRead,
  input logic       parityErrEv,
  input logic       ctsN,
  input logic       intEn,
  input logic       modemIntEn,
  input logic [7:0] statusReg,
  input logic       intr
);
  p_intr_gated_r11: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !intr);

  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(statRead) |-> $stable(statusReg));

  p_read_end_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statRead) |=> ((statusReg & $past(statusReg)) == 8'h00));

  p_read_drops_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !modemIntEn) |=> (!intr || modemIntEn));

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (parityErrEv && !statRead && !$past(statRead)) |=> statusReg[0]);

  p_modem_chg_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((ctsN != $past(ctsN)) && !statRead && !$past(statRead)) |=> statusReg[4]);
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .statRead    (statRead),
  .parityErrEv (parityErrEv),
  .ctsN        (ctsN),
  .intEn       (intEn),
  .modemIntEn  (modemIntEn),
  .statusReg   (statusReg),
  .intr        (intr)
);

// File: tb/sim_uart_stat_irq.sv
`timescale 1ns/1ps
module sim_uart_stat_irq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic parityErrEv = 0, frameErrEv = 0, overrunEv = 0, breakEv = 0, txDoneEv = 0;
  logic dataReady = 0, bufEmpty = 1, ctsN = 1, dsrN = 1;
  logic intEn = 0, modemIntEn = 0, statRead = 0, modemRead = 0;
  logic [7:0] statusReg;
  logic [3:0] modemStat;
  logic intr;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_stat_irq u0 (
    .clk(clk), .rstN(rstN), .parityErrEv(parityErrEv), .frameErrEv(frameErrEv),
    .overrunEv(overrunEv), .breakEv(breakEv), .txDoneEv(txDoneEv),
    .dataReady(dataReady), .bufEmpty(bufEmpty), .ctsN(ctsN), .dsrN(dsrN),
    .intEn(intEn), .modemIntEn(modemIntEn), .statRead(statRead), .modemRead(modemRead),
    .statusReg(statusReg), .modemStat(modemStat), .intr(intr)
  );

  // {txDone, break, overrun, framing, parity} , expected status
  localparam logic [12:0] VEC [7] = '{
    {5'b00001, 8'h01}, {5'b00010, 8'h02}, {5'b00100, 8'h04}, {5'b01000, 8'h08},
    {5'b10000, 8'h20}, {5'b00101, 8'h05}, {5'b11111, 8'h2F}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] e);
    {txDoneEv, breakEv, overrunEv, frameErrEv, parityErrEv} = e;
    @(negedge clk);
    {txDoneEv, breakEv, overrunEv, frameErrEv, parityErrEv} = '0;
  endtask

  task automatic readStat(input int n);
    statRead = 1;
    repeat (n) @(negedge clk);
    statRead = 0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset status", statusReg, 8'h60);
    chk("R1 intr low while disabled", {7'd0, intr}, 8'h01 & 8'h00);
    chk("R8 modem idle", {4'd0, modemStat}, 8'h00);
    intEn = 1;
    #1;
    chk("R1 armed detector", {7'd0, intr}, 8'h01);
    @(negedge clk);
    statRead = 1;
    @(negedge clk);
    chk("R4 intr cleared by read", {7'd0, intr}, 8'h00);
    chk("R5 hold during read", statusReg, 8'h60);
    statRead = 0;
    @(negedge clk);
    chk("R4 cleared after read", statusReg, 8'h00);

    for (int i = 0; i < 7; i++) begin
      pulse(VEC[i][12:8]);
      chk("R2 event bits", statusReg, VEC[i][7:0]);
      chk("R7 edge interrupt", {7'd0, intr}, 8'h01);
      readStat(1);
      chk("R4 read clears status", statusReg, 8'h00);
      chk("R4 read clears intr", {7'd0, intr}, 8'h00);
    end

    dataReady = 1;
    @(negedge clk);
    chk("R3 data ready bit", statusReg, 8'h80);
    chk("R3 data ready no intr", {7'd0, intr}, 8'h00);
    bufEmpty = 0;
    @(negedge clk);
    bufEmpty = 1;
    @(negedge clk);
    chk("R3 buffer empty bit", statusReg, 8'hC0);
    chk("R3 buffer empty no intr", {7'd0, intr}, 8'h00);
    readStat(1);
    chk("R3 held level does not reset bit", statusReg, 8'h00);

    statRead = 1;
    @(negedge clk);
    pulse(5'b00100);
    chk("R5 deferred during read", statusReg, 8'h00);
    statRead = 0;
    @(negedge clk);
    chk("R5 set at read end", statusReg, 8'h04);
    chk("R7 intr at read end", {7'd0, intr}, 8'h01);
    readStat(1);

    pulse(5'b00001);
    chk("R6 bit set before read", statusReg, 8'h01);
    statRead = 1;
    @(negedge clk);
    pulse(5'b00001);
    statRead = 0;
    @(negedge clk);
    chk("R6 toggled clear", statusReg, 8'h00);
    chk("R6 no intr", {7'd0, intr}, 8'h00);

    intEn = 0;
    pulse(5'b10000);
    chk("R11 status set while disabled", statusReg, 8'h20);
    chk("R11 intr gated", {7'd0, intr}, 8'h00);
    intEn = 1;
    #1;
    chk("R11 kept edge fires on enable", {7'd0, intr}, 8'h01);
    @(negedge clk);
    readStat(1);

    ctsN = 0;
    @(negedge clk);
    chk("R9 modem change bit", statusReg, 8'h10);
    chk("R9 no intr without modem enable", {7'd0, intr}, 8'h00);
    chk("R8 cts reported", {4'd0, modemStat}, 8'h01);
    modemIntEn = 1;
    #1;
    chk("R9 modem intr", {7'd0, intr}, 8'h01);
    @(negedge clk);
    modemRead = 1;
    @(negedge clk);
    modemRead = 0;
    chk("R10 modem read clears intr", {7'd0, intr}, 8'h00);
    chk("R10 line bits kept", {4'd0, modemStat}, 8'h01);
    dsrN = 0;
    @(negedge clk);
    chk("R8 dsr reported", {4'd0, modemStat}, 8'h03);
    chk("R9 dsr change intr", {7'd0, intr}, 8'h01);
    intEn = 0;
    #1;
    chk("R11 global gate", {7'd0, intr}, 8'h00);
    @(negedge clk);
    finishRun();
  end
endmodule